// File: doc/BRIEF.md
# Staging Mailbox Chunk Load Sequencer

This block moves one firmware chunk from a local word memory into a staging mailbox and reports what the mailbox answered. A start pulse supplies a byte offset, a byte length and the total image length. The sequencer writes a request object to the mailbox data-in register. The object is a 64-bit size/type header, a 64-bit load command and then the chunk dwords. It then sets the go bit and polls the status register at a fixed cycle interval until ready is seen or the poll budget runs out.

If the mailbox completed cleanly, the sequencer drains a four-dword reply through the data-out register and acknowledges each dword by writing zero back. It then checks the reply header, the next offset and the reply flags. It returns a result code with a one-cycle done pulse and keeps the next offset for the next chunk. Choosing chunk sizes, retrying and walking the whole image are left to the caller.

Top module: `mbox_chunk_loader`

## Requirements
- R1: After synchronous reset, busy, done, reg_req and mem_rd are low, and next_offset and result are zero.
- R2: A run writes to register 0x8, in this order: the header low dword {8'h00, 8'h0B, VENDOR_ID}, the header high dword (16 + chunk_len)/4, then 0x3, then 0x0, then for i = 0 up to chunk_len/4 - 1 the local memory word at address chunk_offset/4 + i. It then writes 0x8000_0000 to register 0x0. The offset and length are multiples of 4, and a zero length sends no data dwords.
- R3: On the register port, reg_req stays high with reg_we, reg_addr and reg_wdata stable until reg_ack is high. Read data is taken while reg_ack is high.
- R4: After go, register 0x4 is read once every POLL_INTERVAL cycles. Polling stops at the first read with bit 31 set, or after POLL_LIMIT reads.
- R5: On the last poll, status bit 2 set gives result 1 (I/O error), even if bit 31 is also set. Otherwise, bit 31 clear gives result 2 (timeout). Neither result reads the reply.
- R6: On a ready poll without error, the reply is fetched as four reads of register 0xC. Each read is followed by a write of zero to 0xC. The words are taken as header low, header high, next offset and flags.
- R7: A reply header other than low {8'h00, 8'h0B, VENDOR_ID} and high 4 gives result 3. This check takes priority over R8 and R9.
- R8: A next offset greater than image_len and not equal to 0xFFFF_FFFF gives result 4. An offset equal to image_len, or equal to the sentinel, passes. This check takes priority over R9.
- R9: Reply flag bit 2 set gives result 5. If no check fails, the result is 0.
- R10: next_offset takes the reply offset only when the result is 0. Otherwise it keeps its previous value.
- R11: busy rises on the cycle after an accepted start and falls with a one-cycle done pulse. result is valid at done and held until the next run. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one chunk transfer (taken when idle) |
| chunk_offset | input | MEM_AW+2 | Byte offset of the chunk in local memory |
| chunk_len | input | LEN_W | Chunk length in bytes |
| image_len | input | 32 | Total image length in bytes, for the offset check |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 I/O error, 2 timeout, 3 bad header, 4 bad offset, 5 protocol error |
| next_offset | output | 32 | Last accepted next offset from the mailbox |
| mem_rd | output | 1 | Local memory read enable |
| mem_addr | output | MEM_AW | Local memory dword address |
| mem_rdata | input | 32 | Local memory data, one cycle after mem_rd |
| reg_req | output | 1 | Register access request, held until ack |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | 4 | Mailbox register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 32 | Read data, valid with reg_ack |

## Verification
A wrong sequencer state shows up at once on the register port. A header word in the wrong place, or a data dword from the wrong memory address, appears in the logged write trace on the first run. A poll counter that is off by one changes the number of status reads and can turn a late ready into a timeout. A misdecoded reply shows in the result code and in next_offset at the done pulse of that same run. A stale next_offset shows up after the next failed check.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_IO    = 3'd1,
    RES_TMO   = 3'd2,
    RES_HDR   = 3'd3,
    RES_OFF   = 3'd4,
    RES_PROTO = 3'd5
  } res_t;

  localparam logic [3:0]  REG_CTRL   = 4'h0;
  localparam logic [3:0]  REG_STAT   = 4'h4;
  localparam logic [3:0]  REG_DIN    = 4'h8;
  localparam logic [3:0]  REG_DOUT   = 4'hC;
  localparam logic [7:0]  OBJ_KIND   = 8'h0B;
  localparam logic [31:0] CMD_LOAD   = 32'h0000_0003;
  localparam logic [31:0] GO_WORD    = 32'h8000_0000;
  localparam logic [31:0] END_MARK   = 32'hFFFF_FFFF;
  localparam logic [31:0] RSP_DWORDS = 32'd4;
  localparam int          READY_BIT  = 31;
  localparam int          ERR_BIT    = 2;

  function automatic logic [31:0] hdr_low(input logic [15:0] vendor);
    return {8'h00, OBJ_KIND, vendor};
  endfunction
endpackage

// File: rtl/mcl_bus_master.sv
module mcl_bus_master (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        go_we,
  input  logic [3:0]  go_addr,
  input  logic [31:0] go_wdata,
  output logic        xfer_done,
  output logic [31:0] xfer_rdata,
  output logic        reg_req,
  output logic        reg_we,
  output logic [3:0]  reg_addr,
  output logic [31:0] reg_wdata,
  input  logic        reg_ack,
  input  logic [31:0] reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_req    <= 1'b0;
      reg_we     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (go) begin
        reg_req   <= 1'b1;
        reg_we    <= go_we;
        reg_addr  <= go_addr;
        reg_wdata <= go_wdata;
      end else if (reg_req && reg_ack) begin
        reg_req    <= 1'b0;
        xfer_done  <= 1'b1;
        xfer_rdata <= reg_rdata;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done); // R3
endmodule

// File: rtl/mcl_poll_timer.sv
module mcl_poll_timer #(
  parameter int INTERVAL = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic fire
);
  localparam int TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt_q <= TW'(INTERVAL - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          fire  <= 1'b1;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R4
endmodule

// File: rtl/mcl_resp_check.sv
module mcl_resp_check #(
  parameter logic [15:0] VENDOR_ID = 16'h5A17
) (
  input  logic [31:0] rsp_hdr_lo,
  input  logic [31:0] rsp_hdr_hi,
  input  logic [31:0] rsp_offset,
  input  logic        rsp_err,
  input  logic [31:0] image_len,
  output logic [2:0]  verdict
);
  import mcl_pkg::*;
  logic hdr_bad, off_bad;

  always_comb begin
    hdr_bad = (rsp_hdr_lo != hdr_low(VENDOR_ID)) || (rsp_hdr_hi != RSP_DWORDS);
    off_bad = (rsp_offset != END_MARK) && (rsp_offset > image_len);
    if (hdr_bad)      verdict = RES_HDR;
    else if (off_bad) verdict = RES_OFF;
    else if (rsp_err) verdict = RES_PROTO;
    else              verdict = RES_OK;
  end
endmodule

// File: rtl/mbox_chunk_loader.sv
module mbox_chunk_loader #(
  parameter int          MEM_AW        = 10,
  parameter int          LEN_W         = 12,
  parameter int          POLL_INTERVAL = 250000,
  parameter int          POLL_LIMIT    = 10000,
  parameter logic [15:0] VENDOR_ID     = 16'h5A17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MEM_AW+1:0] chunk_offset,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic [31:0]       image_len,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [31:0]       next_offset,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [3:0]        reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata
);
  import mcl_pkg::*;

  localparam int NW = LEN_W - 2;
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HLO, S_HHI, S_CLO, S_CHI, S_DRD1, S_DRD2, S_DWR,
    S_GO, S_PWAIT, S_PRD, S_RRD, S_RACK, S_CHECK
  } st_t;

  st_t               st_q;
  logic [NW-1:0]     ndw_q, idx_q;
  logic [31:0]       img_q;
  logic [PW-1:0]     polls_q;
  logic [1:0]        ridx_q;
  logic [31:0]       rsp_q [4];

  logic              bm_go, bm_we, bm_done;
  logic [3:0]        bm_addr;
  logic [31:0]       bm_wdata, bm_rdata;
  logic              tmr_load, tmr_fire;
  logic [2:0]        verdict;
  logic              last_poll;

  mcl_bus_master u_bus (
    .clk(clk), .rst(rst),
    .go(bm_go), .go_we(bm_we), .go_addr(bm_addr), .go_wdata(bm_wdata),
    .xfer_done(bm_done), .xfer_rdata(bm_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  mcl_poll_timer #(.INTERVAL(POLL_INTERVAL)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .fire(tmr_fire)
  );

  mcl_resp_check #(.VENDOR_ID(VENDOR_ID)) u_chk (
    .rsp_hdr_lo(rsp_q[0]), .rsp_hdr_hi(rsp_q[1]), .rsp_offset(rsp_q[2]),
    .rsp_err(rsp_q[3][ERR_BIT]), .image_len(img_q), .verdict(verdict)
  );

  assign last_poll = (polls_q + 1'b1) == PW'(POLL_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      ndw_q       <= '0;
      idx_q       <= '0;
      img_q       <= '0;
      polls_q     <= '0;
      ridx_q      <= '0;
      for (int k = 0; k < 4; k++) rsp_q[k] <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      result      <= '0;
      next_offset <= '0;
      mem_rd      <= 1'b0;
      mem_addr    <= '0;
      bm_go       <= 1'b0;
      bm_we       <= 1'b0;
      bm_addr     <= '0;
      bm_wdata    <= '0;
      tmr_load    <= 1'b0;
    end else begin
      bm_go    <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          ndw_q    <= chunk_len[LEN_W-1:2];
          img_q    <= image_len;
          mem_addr <= chunk_offset[MEM_AW+1:2];
          busy     <= 1'b1;
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DIN;
          bm_wdata <= hdr_low(VENDOR_ID);
          st_q     <= S_HLO;
        end
        S_HLO: if (bm_done) begin
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DIN;
          bm_wdata <= 32'(ndw_q) + 32'd4;
          st_q     <= S_HHI;
        end
        S_HHI: if (bm_done) begin
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DIN;
          bm_wdata <= CMD_LOAD;
          st_q     <= S_CLO;
        end
        S_CLO: if (bm_done) begin
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DIN;
          bm_wdata <= '0;
          st_q     <= S_CHI;
        end
        S_CHI: if (bm_done) begin
          if (ndw_q == '0) begin
            bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_CTRL;
            bm_wdata <= GO_WORD;
            st_q     <= S_GO;
          end else begin
            idx_q  <= '0;
            mem_rd <= 1'b1;
            st_q   <= S_DRD1;
          end
        end
        S_DRD1: begin
          mem_rd <= 1'b0;
          st_q   <= S_DRD2;
        end
        S_DRD2: begin
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DIN;
          bm_wdata <= mem_rdata;
          st_q     <= S_DWR;
        end
        S_DWR: if (bm_done) begin
          if (idx_q == ndw_q - 1'b1) begin
            bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_CTRL;
            bm_wdata <= GO_WORD;
            st_q     <= S_GO;
          end else begin
            idx_q    <= idx_q + 1'b1;
            mem_addr <= mem_addr + 1'b1;
            mem_rd   <= 1'b1;
            st_q     <= S_DRD1;
          end
        end
        S_GO: if (bm_done) begin
          polls_q  <= '0;
          tmr_load <= 1'b1;
          st_q     <= S_PWAIT;
        end
        S_PWAIT: if (tmr_fire) begin
          bm_go   <= 1'b1; bm_we <= 1'b0; bm_addr <= REG_STAT;
          st_q    <= S_PRD;
        end
        S_PRD: if (bm_done) begin
          polls_q <= polls_q + 1'b1;
          if (bm_rdata[READY_BIT] || last_poll) begin
            if (bm_rdata[ERR_BIT]) begin
              result <= RES_IO; done <= 1'b1; busy <= 1'b0; st_q <= S_IDLE;
            end else if (!bm_rdata[READY_BIT]) begin
              result <= RES_TMO; done <= 1'b1; busy <= 1'b0; st_q <= S_IDLE;
            end else begin
              ridx_q <= '0;
              bm_go  <= 1'b1; bm_we <= 1'b0; bm_addr <= REG_DOUT;
              st_q   <= S_RRD;
            end
          end else begin
            tmr_load <= 1'b1;
            st_q     <= S_PWAIT;
          end
        end
        S_RRD: if (bm_done) begin
          rsp_q[ridx_q] <= bm_rdata;
          bm_go    <= 1'b1; bm_we <= 1'b1; bm_addr <= REG_DOUT;
          bm_wdata <= '0;
          st_q     <= S_RACK;
        end
        S_RACK: if (bm_done) begin
          if (ridx_q == 2'd3) begin
            st_q <= S_CHECK;
          end else begin
            ridx_q <= ridx_q + 1'b1;
            bm_go  <= 1'b1; bm_we <= 1'b0; bm_addr <= REG_DOUT;
            st_q   <= S_RRD;
          end
        end
        S_CHECK: begin
          result <= verdict;
          if (verdict == RES_OK) next_offset <= rsp_q[2];
          done <= 1'b1;
          busy <= 1'b0;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> (chunk_len[1:0] == 2'b00 && chunk_offset[1:0] == 2'b00)); // R2
  AST_MEM_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R11
  AST_NEXT_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
    !$stable(next_offset) |-> (done && result == RES_OK)); // R10
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (rst)
    done |-> (result <= 3'd5)); // R9
endmodule

// File: tb/mbox_chunk_loader_tb.sv
module mbox_chunk_loader_tb;
  localparam int          MEM_AW = 6;
  localparam int          LEN_W  = 8;
  localparam int          PINT   = 3;
  localparam int          PLIM   = 5;
  localparam logic [15:0] VID    = 16'h5A17;
  localparam logic [31:0] HLO    = {8'h00, 8'h0B, VID};

  typedef struct packed {
    logic [7:0]  off;
    logic [7:0]  len;
    logic [31:0] img;
    logic [7:0]  rdy;
    logic        serr;
    logic        hbad;
    logic [31:0] roff;
    logic [31:0] rstat;
    logic [2:0]  res;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd8,  32'd256, 8'd1,  1'b0, 1'b0, 32'd8,          32'h1, 3'd0},
    '{8'd16, 8'd16, 32'd256, 8'd3,  1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 3'd0},
    '{8'd8,  8'd4,  32'd64,  8'd2,  1'b0, 1'b0, 32'd64,         32'h1, 3'd0},
    '{8'd0,  8'd4,  32'd64,  8'd1,  1'b0, 1'b0, 32'd65,         32'h1, 3'd4},
    '{8'd4,  8'd8,  32'd64,  8'd1,  1'b0, 1'b1, 32'd12,         32'h1, 3'd3},
    '{8'd0,  8'd4,  32'd64,  8'd1,  1'b0, 1'b0, 32'd4,          32'h4, 3'd5},
    '{8'd0,  8'd4,  32'd64,  8'd1,  1'b1, 1'b0, 32'd4,          32'h1, 3'd1},
    '{8'd0,  8'd4,  32'd64,  8'd99, 1'b0, 1'b0, 32'd4,          32'h1, 3'd2},
    '{8'd0,  8'd4,  32'd64,  8'd1,  1'b0, 1'b1, 32'd99,         32'h4, 3'd3},
    '{8'd12, 8'd0,  32'd64,  8'd1,  1'b0, 1'b0, 32'd0,          32'h1, 3'd0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [MEM_AW+1:0] chunk_offset = '0;
  logic [LEN_W-1:0]  chunk_len = '0;
  logic [31:0]       image_len = '0;
  logic busy, done, mem_rd, reg_req, reg_we;
  logic [2:0] result;
  logic [31:0] next_offset, reg_wdata;
  logic [MEM_AW-1:0] mem_addr;
  logic [3:0] reg_addr;
  logic [31:0] mem_rdata = '0, reg_rdata = '0;
  logic reg_ack = 1'b0;

  always #2 clk = ~clk;

  mbox_chunk_loader #(.MEM_AW(MEM_AW), .LEN_W(LEN_W), .POLL_INTERVAL(PINT),
                      .POLL_LIMIT(PLIM), .VENDOR_ID(VID)) u_dut (
    .clk(clk), .rst(rst), .start(start), .chunk_offset(chunk_offset),
    .chunk_len(chunk_len), .image_len(image_len), .busy(busy), .done(done),
    .result(result), .next_offset(next_offset), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .reg_req(reg_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata));

  // slave configuration, driven by the initial block only
  logic        clr = 1'b0;
  logic [7:0]  cfg_rdy = 8'd1;
  logic        cfg_serr = 1'b0;
  logic [31:0] cfg_rsp [4];

  // mailbox model and transaction log
  int          lg_n = 0;
  int          stat_n = 0;
  int          rsp_i = 0;
  logic        lg_we   [64];
  logic [3:0]  lg_addr [64];
  logic [31:0] lg_data [64];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= 32'hC0DE_0000 | 32'(mem_addr);
    if (clr) begin
      lg_n <= 0; stat_n <= 0; rsp_i <= 0; reg_ack <= 1'b0;
    end else if (reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      if (lg_n < 64) begin
        lg_we[lg_n]   <= reg_we;
        lg_addr[lg_n] <= reg_addr;
      end
      if (reg_we) begin
        if (lg_n < 64) lg_data[lg_n] <= reg_wdata;
        if (reg_addr == 4'hC) rsp_i <= rsp_i + 1;
      end else if (reg_addr == 4'h4) begin
        reg_rdata <= ((stat_n + 1 >= int'(cfg_rdy)) ? 32'h8000_0000 : 32'h0) |
                     (cfg_serr ? 32'h4 : 32'h0);
        if (lg_n < 64) lg_data[lg_n] <= 32'h0;
        stat_n <= stat_n + 1;
      end else begin
        reg_rdata <= cfg_rsp[rsp_i % 4];
        if (lg_n < 64) lg_data[lg_n] <= cfg_rsp[rsp_i % 4];
      end
      lg_n <= lg_n + 1;
    end else begin
      reg_ack <= 1'b0;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk({req, " done timeout"}, 32'd0, 32'd1);
  endtask

  // expected trace
  logic        ex_we   [64];
  logic [3:0]  ex_addr [64];
  logic [31:0] ex_data [64];

  task automatic run_vec(input vec_t v, input int vi, inout logic [31:0] exp_nxt);
    int n = 0;
    int polls;
    cfg_rdy    = v.rdy;
    cfg_serr   = v.serr;
    cfg_rsp[0] = HLO;
    cfg_rsp[1] = v.hbad ? 32'd5 : 32'd4;
    cfg_rsp[2] = v.roff;
    cfg_rsp[3] = v.rstat;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chunk_offset = v.off[MEM_AW+1:0];
    chunk_len    = v.len;
    image_len    = v.img;
    start        = 1'b1;
    @(negedge clk); start = 1'b0;
    chk($sformatf("R11 busy high v%0d", vi), 32'(busy), 32'd1);
    wait_done($sformatf("R11 v%0d", vi));
    chk($sformatf("R5 R7 R8 R9 result v%0d", vi), 32'(result), 32'(v.res));
    if (v.res == 3'd0) exp_nxt = v.roff;
    chk($sformatf("R10 next_offset v%0d", vi), next_offset, exp_nxt);
    // build expected register trace (R2, R4, R6)
    ex_we[0] = 1; ex_addr[0] = 4'h8; ex_data[0] = HLO;
    ex_we[1] = 1; ex_addr[1] = 4'h8; ex_data[1] = 32'(v.len) / 4 + 32'd4;
    ex_we[2] = 1; ex_addr[2] = 4'h8; ex_data[2] = 32'h3;
    ex_we[3] = 1; ex_addr[3] = 4'h8; ex_data[3] = 32'h0;
    n = 4;
    for (int i = 0; i < int'(v.len) / 4; i++) begin
      ex_we[n] = 1; ex_addr[n] = 4'h8; ex_data[n] = 32'hC0DE_0000 | 32'(int'(v.off) / 4 + i);
      n++;
    end
    ex_we[n] = 1; ex_addr[n] = 4'h0; ex_data[n] = 32'h8000_0000; n++;
    polls = (int'(v.rdy) < PLIM) ? int'(v.rdy) : PLIM;
    for (int i = 0; i < polls; i++) begin
      ex_we[n] = 0; ex_addr[n] = 4'h4; ex_data[n] = 32'h0; n++;
    end
    if (v.res != 3'd1 && v.res != 3'd2) begin
      for (int i = 0; i < 4; i++) begin
        ex_we[n] = 0; ex_addr[n] = 4'hC; ex_data[n] = cfg_rsp[i]; n++;
        ex_we[n] = 1; ex_addr[n] = 4'hC; ex_data[n] = 32'h0; n++;
      end
    end
    chk($sformatf("R2 R4 R6 trace length v%0d", vi), 32'(lg_n), 32'(n));
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk($sformatf("R2 R4 R6 entry %0d v%0d", i, vi),
          {lg_we[i], 23'd0, lg_addr[i], 4'd0}, {ex_we[i], 23'd0, ex_addr[i], 4'd0});
      if (ex_we[i] || ex_addr[i] == 4'hC)
        chk($sformatf("R2 R6 data %0d v%0d", i, vi), lg_data[i], ex_data[i]);
    end
    @(negedge clk);
    chk($sformatf("R11 done pulse v%0d", vi), {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] nxt = 32'd0;
    int hold_n;
    logic [2:0] hold_res;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; clr = 1'b0;
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 next_offset", next_offset, 32'd0);
    chk("R1 result", 32'(result), 32'd0);
    chk("R1 reg_req mem_rd", {30'd0, reg_req, mem_rd}, 32'd0);

    for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi, nxt);

    // R11: start while busy is ignored; result held after done
    run_vec(VECS[0], 100, nxt);
    cfg_rdy = 8'd2;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chunk_offset = 8'd4; chunk_len = 8'd4; image_len = 32'd64;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chunk_offset = 8'd32; chunk_len = 8'd16;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done("R11 restart");
    chk("R11 start while busy ignored, trace length", 32'(lg_n), 32'd4 + 1 + 1 + 2 + 8);
    chk("R11 first data word unchanged", lg_data[4], 32'hC0DE_0001);
    chk("R10 next_offset after restart", next_offset, 32'd8);
    hold_res = result;
    hold_n = lg_n;
    repeat (12) @(negedge clk);
    chk("R11 result held", 32'(result), 32'(hold_res));
    chk("R11 idle no accesses", 32'(lg_n), 32'(hold_n));
    chk("R11 idle busy low", 32'(busy), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule